// File: doc/BRIEF.md
# AUX Request Framing and Retry Sequencer

This engine sits between a requester and an AUX channel controller. A requester hands it one transaction: a 4-bit command code, a 20-bit address, a byte count and up to sixteen bytes of write data. The engine first classifies the command and rejects malformed or oversized requests. It then checks that the controller is idle and builds the request header. It presents the frame and its transmit length to the controller and starts the transfer.

Each attempt ends with a completion pulse from the controller. The engine acknowledges every completion with a clear pulse. A timeout is retried at once. A receive error is retried only after a fixed pause. Success ends the loop, and the attempt limit ends it too. On success the engine extracts the reply code and either the read payload and its length or the number of bytes the sink accepted on a write. Each request ends with a one-cycle result pulse that carries a status code and a byte count.

Frames travel most-significant byte first: byte 0 of any frame sits in the top eight bits of its bus.

Top module: `aux_req_seq`

## Requirements
- R1: The transmitted frame carries header byte 0 = {command, address[19:16]}, byte 1 = address[15:8], byte 2 = address[7:0] and byte 3 = count−1. On a write, the payload bytes follow from byte 4, in the order in which they sit in `req_wdata` (MSB first).
- R2: The transmit length is 3 when the count is zero (address only). Otherwise it is count+4 for a write and 4 for a read. The receive limit `ctl_rx_max` is 2 for a write and count+1 for a read.
- R3: Command bit 2 is ignored when classifying. 0x8, 0x0 and 0x2 are writes, and 0x9 and 0x1 are reads. Any other code ends the request with status 5 (bad request), count 0 and no transfer.
- R4: A write with count above 16, or a read with count above 19, ends with status 4 (too big), count 0 and no transfer.
- R5: `ctl_busy` is sampled up to 3 times, `POLL_GAP_CYC` cycles apart. If it is set at all three samples, the request ends with status 1 (busy) and no transfer. If it clears at any sample, the transfer starts.
- R6: At most 5 `ctl_start` pulses are issued per request. After a timeout the next start follows as soon as possible. After a receive error it comes exactly `RXERR_WAIT_CYC` cycles later than it would after a timeout. A completion with neither error ends the retries.
- R7: Every `ctl_done` is answered by a one-cycle `ctl_clear` in the following cycle.
- R8: When the fifth attempt fails, the status is 2 (receive error) if its receive-error flag is set, even when the timeout flag is set as well. Otherwise the status is 3 (timeout).
- R9: For a successful read, the reply is the upper nibble of received byte 0 and the count is min(rx length, count+1)−1. The payload starts at received byte 1 in the top byte of `rsp_rdata`.
- R10: For a successful write, if the clamped reply length is 2, the count is min(received byte 1, requested count). Otherwise the count is the requested count. The reply is the upper nibble of byte 0.
- R11: A clean completion that reports a receive length of 0 or above 20 ends with status 1 (busy), count 0.
- R12: Status 0 means ok. `rsp_valid` is a single-cycle pulse. `req_ready` is high only while idle, and a `req_valid` seen while not ready is ignored. After reset `req_ready` is 1 and `ctl_start`, `ctl_clear` and `rsp_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request strobe, taken when `req_ready` is high |
| req_ready | output | 1 | Engine idle |
| req_cmd | input | 4 | Command code |
| req_addr | input | 20 | Target address |
| req_len | input | 5 | Byte count |
| req_wdata | input | 128 | Write payload, byte 0 in bits 127:120 |
| ctl_start | output | 1 | Start one attempt |
| ctl_clear | output | 1 | Clear done and error flags |
| ctl_tx_len | output | 5 | Bytes to transmit |
| ctl_tx_data | output | 160 | Frame to transmit, byte 0 in bits 159:152 |
| ctl_rx_max | output | 5 | Reply bytes expected at most |
| ctl_busy | input | 1 | Controller busy flag |
| ctl_done | input | 1 | Attempt completed |
| ctl_timeout | input | 1 | Attempt timed out |
| ctl_rx_err | input | 1 | Attempt saw a receive error |
| ctl_rx_len | input | 5 | Bytes received |
| ctl_rx_data | input | 160 | Received frame, byte 0 in bits 159:152 |
| rsp_valid | output | 1 | Result pulse |
| rsp_status | output | 3 | 0 ok, 1 busy, 2 rx error, 3 timeout, 4 too big, 5 bad request |
| rsp_reply | output | 4 | Reply code |
| rsp_count | output | 5 | Payload or accepted byte count |
| rsp_rdata | output | 152 | Read payload, first byte in bits 151:144 |

## Verification
The bench goes after the size edges: a 16-byte write against a 17-byte write, a 19-byte read against a 20-byte read, and the address-only form. A wrong comparison there would start a transfer that should be refused, or refuse a legal one. It drives short-write replies below and above the requested count, and replies longer than the limit or of illegal length. A missing clamp would report more bytes than were asked for. The retry tests measure the start-to-start spacing after a timeout against the spacing after a receive error. They also set both flags on the last attempt, so an engine that pauses on the wrong error or ranks the flags the wrong way shows up in the spacing or the status. A controller held busy through all three polls, and one released between polls, show whether the poll count and gap are honoured.

// File: rtl/aux_req_seq.sv
module aux_req_seq #(
  parameter int FRAME_BYTES    = 20,
  parameter int ATTEMPTS       = 5,
  parameter int BUSY_POLLS     = 3,
  parameter int POLL_GAP_CYC   = 1000,
  parameter int RXERR_WAIT_CYC = 400,
  localparam int CW = $clog2(FRAME_BYTES + 1),
  localparam int FW = 8 * FRAME_BYTES,
  localparam int WW = 8 * (FRAME_BYTES - 4),
  localparam int RW = 8 * (FRAME_BYTES - 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [3:0]    req_cmd,
  input  logic [19:0]   req_addr,
  input  logic [CW-1:0] req_len,
  input  logic [WW-1:0] req_wdata,
  output logic          ctl_start,
  output logic          ctl_clear,
  output logic [CW-1:0] ctl_tx_len,
  output logic [FW-1:0] ctl_tx_data,
  output logic [CW-1:0] ctl_rx_max,
  input  logic          ctl_busy,
  input  logic          ctl_done,
  input  logic          ctl_timeout,
  input  logic          ctl_rx_err,
  input  logic [CW-1:0] ctl_rx_len,
  input  logic [FW-1:0] ctl_rx_data,
  output logic          rsp_valid,
  output logic [2:0]    rsp_status,
  output logic [3:0]    rsp_reply,
  output logic [CW-1:0] rsp_count,
  output logic [RW-1:0] rsp_rdata
);

  localparam int WR_MAX = FRAME_BYTES - 4;
  localparam int RD_MAX = FRAME_BYTES - 1;
  localparam int TMAX   = (POLL_GAP_CYC > RXERR_WAIT_CYC) ? POLL_GAP_CYC : RXERR_WAIT_CYC;
  localparam int TW     = $clog2(TMAX + 1);
  localparam int AW     = $clog2(ATTEMPTS + 1);
  localparam int PW     = $clog2(BUSY_POLLS + 1);

  localparam logic [2:0] ST_OK = 3'd0, ST_BUSY = 3'd1, ST_RXE = 3'd2,
                         ST_TO = 3'd3, ST_BIG = 3'd4, ST_BAD = 3'd5;

  typedef enum logic [2:0] {
    S_IDLE, S_EVAL, S_POLL, S_GAP, S_SEND, S_WAIT, S_JUDGE, S_PAUSE
  } state_t;

  state_t state, nxt;

  logic [3:0]    cmd_q;
  logic [19:0]   addr_q;
  logic [CW-1:0] len_q;
  logic [WW-1:0] wdata_q;
  logic [TW-1:0] tmr;
  logic [AW-1:0] tries;
  logic [PW-1:0] polls;
  logic          to_q, re_q;
  logic [CW-1:0] rxlen_q;
  logic [3:0]    rx_code_q;
  logic [RW-1:0] rx_body_q;

  logic          fin;
  logic [2:0]    fin_st;

  wire [3:0] kind   = cmd_q & 4'b1011;
  wire       is_wr  = (kind == 4'h8) || (kind == 4'h0) || (kind == 4'h2);
  wire       is_rd  = (kind == 4'h9) || (kind == 4'h1);
  wire       too_big = (is_wr && len_q > CW'(WR_MAX)) || (is_rd && len_q > CW'(RD_MAX));

  assign ctl_tx_len  = (len_q == '0) ? CW'(3) : (is_wr ? len_q + CW'(4) : CW'(4));
  assign ctl_rx_max  = is_wr ? CW'(2) : len_q + CW'(1);
  assign ctl_tx_data = {cmd_q, addr_q[19:16], addr_q[15:8], addr_q[7:0],
                        8'(len_q) - 8'd1, wdata_q};

  wire [CW-1:0] n_clamp = (rxlen_q > ctl_rx_max) ? ctl_rx_max : rxlen_q;
  wire          bad_len = (rxlen_q == '0) || (rxlen_q > CW'(FRAME_BYTES));
  wire [7:0]    byte1   = rx_body_q[RW-1 -: 8];
  wire [CW-1:0] wr_cnt  = (n_clamp > CW'(1)) ?
                          ((byte1 > 8'(len_q)) ? len_q : CW'(byte1)) : len_q;
  wire [CW-1:0] rd_cnt  = n_clamp - CW'(1);

  assign req_ready = (state == S_IDLE);
  assign ctl_start = (state == S_SEND);
  assign ctl_clear = (state == S_JUDGE);

  always_comb begin
    nxt    = state;
    fin    = 1'b0;
    fin_st = ST_OK;
    case (state)
      S_IDLE:  if (req_valid) nxt = S_EVAL;
      S_EVAL: begin
        if (!(is_wr || is_rd))  begin fin = 1'b1; fin_st = ST_BAD; end
        else if (too_big)       begin fin = 1'b1; fin_st = ST_BIG; end
        else                    nxt = S_POLL;
      end
      S_POLL: begin
        if (!ctl_busy)                          nxt = S_SEND;
        else if (polls == PW'(BUSY_POLLS - 1))  begin fin = 1'b1; fin_st = ST_BUSY; end
        else                                    nxt = S_GAP;
      end
      S_GAP:   if (tmr == TW'(POLL_GAP_CYC - 1)) nxt = S_POLL;
      S_SEND:  nxt = S_WAIT;
      S_WAIT:  if (ctl_done) nxt = S_JUDGE;
      S_JUDGE: begin
        if (!to_q && !re_q) begin
          fin    = 1'b1;
          fin_st = bad_len ? ST_BUSY : ST_OK;
        end else if (tries == AW'(ATTEMPTS - 1)) begin
          fin    = 1'b1;
          fin_st = re_q ? ST_RXE : ST_TO;
        end else begin
          nxt = to_q ? S_SEND : S_PAUSE;
        end
      end
      S_PAUSE: if (tmr == TW'(RXERR_WAIT_CYC - 1)) nxt = S_SEND;
      default: nxt = S_IDLE;
    endcase
    if (fin) nxt = S_IDLE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= S_IDLE;
      cmd_q      <= '0;
      addr_q     <= '0;
      len_q      <= '0;
      wdata_q    <= '0;
      tmr        <= '0;
      tries      <= '0;
      polls      <= '0;
      to_q       <= 1'b0;
      re_q       <= 1'b0;
      rxlen_q    <= '0;
      rx_code_q  <= '0;
      rx_body_q  <= '0;
      rsp_valid  <= 1'b0;
      rsp_status <= ST_OK;
      rsp_reply  <= '0;
      rsp_count  <= '0;
      rsp_rdata  <= '0;
    end else begin
      state     <= nxt;
      rsp_valid <= fin;
      if (state == S_IDLE && req_valid) begin
        cmd_q   <= req_cmd;
        addr_q  <= req_addr;
        len_q   <= req_len;
        wdata_q <= req_wdata;
      end
      if (state == S_EVAL) polls <= '0;
      if (state == S_POLL && nxt == S_GAP) polls <= polls + PW'(1);
      if (state == S_POLL && nxt == S_SEND) tries <= '0;
      if (state == S_JUDGE && !fin) tries <= tries + AW'(1);
      if (nxt == S_GAP || nxt == S_PAUSE) begin
        tmr <= (state == nxt) ? tmr + TW'(1) : '0;
      end
      if (state == S_WAIT && ctl_done) begin
        to_q      <= ctl_timeout;
        re_q      <= ctl_rx_err;
        rxlen_q   <= ctl_rx_len;
        rx_code_q <= ctl_rx_data[FW-1 -: 4];
        rx_body_q <= ctl_rx_data[RW-1:0];
      end
      if (fin) begin
        rsp_status <= fin_st;
        if (fin_st == ST_OK) begin
          rsp_reply <= rx_code_q;
          rsp_count <= is_wr ? wr_cnt : rd_cnt;
          rsp_rdata <= rx_body_q;
        end else begin
          rsp_reply <= '0;
          rsp_count <= '0;
          rsp_rdata <= '0;
        end
      end
    end
  end

endmodule

module aux_req_seq_chk #(
  parameter int ATTEMPTS    = 5,
  parameter int FRAME_BYTES = 20,
  parameter int CW          = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          req_ready,
  input logic          ctl_start,
  input logic          ctl_clear,
  input logic          ctl_done,
  input logic          rsp_valid,
  input logic [2:0]    rsp_status,
  input logic [CW-1:0] rsp_count
);
  int starts;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) starts <= 0;
    else if (req_valid && req_ready) starts <= 0;
    else if (ctl_start) starts <= starts + 1;
  end

  p_attempt_cap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    starts <= ATTEMPTS);
  p_ok_after_start_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_status == 3'd0) |-> starts >= 1);
  p_bad_nostart_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_status == 3'd5) |-> starts == 0);
  p_big_nostart_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_status == 3'd4) |-> starts == 0);
  p_clear_follows_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_clear |-> $past(ctl_done));
  p_single_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);
  p_not_ready_in_flight_r12: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_start |-> !req_ready);
  p_count_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_status == 3'd0) |-> rsp_count <= CW'(FRAME_BYTES - 1));
endmodule

bind aux_req_seq aux_req_seq_chk #(.ATTEMPTS(ATTEMPTS), .FRAME_BYTES(FRAME_BYTES), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .ctl_start(ctl_start), .ctl_clear(ctl_clear), .ctl_done(ctl_done),
  .rsp_valid(rsp_valid), .rsp_status(rsp_status), .rsp_count(rsp_count)
);

// File: tb/tb_aux_req_seq.sv
module tb_aux_req_seq;
  localparam int CLK_PERIOD = 10;
  localparam int F    = 20;
  localparam int GAP  = 50;
  localparam int RXW  = 20;
  localparam int CW   = 5;
  localparam int FW   = 8 * F;
  localparam int WW   = 8 * (F - 4);
  localparam int RW   = 8 * (F - 1);
  localparam int NV   = 15;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_ready;
  logic [3:0] req_cmd = '0;
  logic [19:0] req_addr = '0;
  logic [CW-1:0] req_len = '0;
  logic [WW-1:0] req_wdata;
  logic ctl_start, ctl_clear;
  logic [CW-1:0] ctl_tx_len, ctl_rx_max;
  logic [FW-1:0] ctl_tx_data;
  logic ctl_busy = 1'b0, ctl_done = 1'b0, ctl_timeout = 1'b0, ctl_rx_err = 1'b0;
  logic [CW-1:0] ctl_rx_len = '0;
  logic [FW-1:0] ctl_rx_data = '0;
  logic rsp_valid;
  logic [2:0] rsp_status;
  logic [3:0] rsp_reply;
  logic [CW-1:0] rsp_count;
  logic [RW-1:0] rsp_rdata;

  aux_req_seq #(.FRAME_BYTES(F), .POLL_GAP_CYC(GAP), .RXERR_WAIT_CYC(RXW)) dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checks = 0, failures = 0;
  bit done_flag = 0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // cmd, addr, len, rxlen, rx0, rx1, status, count, txlen, rxmax
  localparam logic [67:0] VEC [NV] = '{
    {4'h9, 20'h12345, 5'd4,  5'd5,  8'h00, 8'h11, 3'd0, 5'd4,  5'd4,  5'd5},
    {4'h8, 20'hABCDE, 5'd3,  5'd1,  8'h00, 8'h00, 3'd0, 5'd3,  5'd7,  5'd2},
    {4'h4, 20'h00050, 5'd0,  5'd1,  8'h00, 8'h00, 3'd0, 5'd0,  5'd3,  5'd2},
    {4'h8, 20'h00100, 5'd16, 5'd2,  8'h00, 8'h05, 3'd0, 5'd5,  5'd20, 5'd2},
    {4'h8, 20'h00200, 5'd4,  5'd2,  8'h00, 8'h09, 3'd0, 5'd4,  5'd8,  5'd2},
    {4'h8, 20'h00300, 5'd17, 5'd1,  8'h00, 8'h00, 3'd4, 5'd0,  5'd0,  5'd0},
    {4'h9, 20'h00400, 5'd19, 5'd20, 8'h10, 8'h77, 3'd0, 5'd19, 5'd4,  5'd20},
    {4'h9, 20'h00500, 5'd20, 5'd1,  8'h00, 8'h00, 3'd4, 5'd0,  5'd0,  5'd0},
    {4'h3, 20'h00600, 5'd1,  5'd1,  8'h00, 8'h00, 3'd5, 5'd0,  5'd0,  5'd0},
    {4'hA, 20'h00700, 5'd1,  5'd1,  8'h00, 8'h00, 3'd5, 5'd0,  5'd0,  5'd0},
    {4'h9, 20'h00800, 5'd8,  5'd3,  8'h20, 8'h44, 3'd0, 5'd2,  5'd4,  5'd9},
    {4'h9, 20'h00900, 5'd2,  5'd25, 8'h00, 8'h00, 3'd1, 5'd0,  5'd4,  5'd3},
    {4'h9, 20'h00A00, 5'd2,  5'd0,  8'h00, 8'h00, 3'd1, 5'd0,  5'd4,  5'd3},
    {4'h5, 20'h00B00, 5'd1,  5'd9,  8'h10, 8'h66, 3'd0, 5'd1,  5'd4,  5'd2},
    {4'h2, 20'h00C00, 5'd1,  5'd1,  8'h00, 8'h00, 3'd0, 5'd1,  5'd5,  5'd2}
  };

  logic [1:0] script [8];
  int n_starts, n_clears, acc_cyc, rsp_cyc;
  int start_cyc [8];
  bit got_rsp, inject;
  logic [CW-1:0] drv_rxlen;
  logic [7:0] drv_rx0, drv_rx1;
  logic [2:0] got_st;
  logic [3:0] got_reply;
  logic [CW-1:0] got_cnt, cap_txlen, cap_rxmax;
  logic [RW-1:0] got_rdata;
  logic [FW-1:0] cap_tx;

  function automatic logic [FW-1:0] rx_frame();
    logic [FW-1:0] fr;
    for (int k = 0; k < F; k++) fr[FW-1-8*k -: 8] = 8'h30 + 8'(k);
    fr[FW-1 -: 8] = drv_rx0;
    fr[FW-9 -: 8] = drv_rx1;
    return fr;
  endfunction

  task automatic transact(input logic [3:0] c, input logic [19:0] a, input logic [CW-1:0] l);
    @(negedge clk);
    req_cmd = c; req_addr = a; req_len = l; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    acc_cyc = cyc;
    n_starts = 0; n_clears = 0; got_rsp = 0;
    for (int i = 0; i < 20000 && !got_rsp; i++) begin
      if (rsp_valid) begin
        got_rsp = 1; rsp_cyc = cyc;
        got_st = rsp_status; got_cnt = rsp_count; got_reply = rsp_reply; got_rdata = rsp_rdata;
      end else if (ctl_start) begin
        if (n_starts < 8) start_cyc[n_starts] = cyc;
        cap_txlen = ctl_tx_len; cap_tx = ctl_tx_data; cap_rxmax = ctl_rx_max;
        if (inject) begin req_valid = 1'b1; req_cmd = 4'hF; end
        @(negedge clk);
        req_valid = 1'b0;
        @(negedge clk);
        ctl_done = 1'b1;
        ctl_timeout = script[n_starts % 8][1];
        ctl_rx_err  = script[n_starts % 8][0];
        ctl_rx_len  = drv_rxlen;
        ctl_rx_data = rx_frame();
        n_starts++;
        @(negedge clk);
        ctl_done = 1'b0; ctl_timeout = 1'b0; ctl_rx_err = 1'b0;
        if (ctl_clear) n_clears++;
      end
      if (!got_rsp) @(negedge clk);
    end
    if (!got_rsp) chk(1'b0, "watchdog no response", 0, 1);
  endtask

  task automatic set_script(input logic [1:0] s0, s1, s2, s3, s4);
    script[0] = s0; script[1] = s1; script[2] = s2; script[3] = s3; script[4] = s4;
    script[5] = 2'b00; script[6] = 2'b00; script[7] = 2'b00;
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    failures++;
    $display("FAIL watchdog expired actual=0 expected=1");
    finish_run();
  end

  initial begin
    int gap_to, gap_re;
    for (int k = 0; k < F - 4; k++) req_wdata[WW-1-8*k -: 8] = 8'hA0 + 8'(k);
    inject = 0;
    set_script(2'b00, 2'b00, 2'b00, 2'b00, 2'b00);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R12 reset state
    chk(req_ready == 1'b1, "R12 reset ready", req_ready, 1);
    chk({ctl_start, ctl_clear, rsp_valid} == 3'b000, "R12 reset outputs",
        {ctl_start, ctl_clear, rsp_valid}, 0);

    for (int v = 0; v < NV; v++) begin
      logic [67:0] e;
      logic [3:0] c; logic [19:0] a; logic [4:0] l, rl, ecnt, etx, erx; logic [7:0] r0, r1; logic [2:0] est;
      e = VEC[v];
      {c, a, l, rl, r0, r1, est, ecnt, etx, erx} = e;
      drv_rxlen = rl; drv_rx0 = r0; drv_rx1 = r1;
      transact(c, a, l);
      chk(got_st == est, $sformatf("R3 R4 R11 status vec%0d", v), got_st, est);
      chk(got_cnt == ecnt, $sformatf("R9 R10 count vec%0d", v), got_cnt, ecnt);
      if (est >= 3'd4) begin
        chk(n_starts == 0, $sformatf("R3 R4 no start vec%0d", v), n_starts, 0);
      end else begin
        chk(n_starts == 1, $sformatf("R6 one start vec%0d", v), n_starts, 1);
        chk(n_clears == 1, $sformatf("R7 clear vec%0d", v), n_clears, 1);
        chk(cap_txlen == etx, $sformatf("R2 txlen vec%0d", v), cap_txlen, etx);
        chk(cap_rxmax == erx, $sformatf("R2 rxmax vec%0d", v), cap_rxmax, erx);
        chk(cap_tx[FW-1 -: 24] == {c, a}, $sformatf("R1 header vec%0d", v), cap_tx[FW-1 -: 24], {c, a});
        if (l != 0) chk(cap_tx[FW-25 -: 8] == 8'(l) - 8'd1, $sformatf("R1 len byte vec%0d", v),
                        cap_tx[FW-25 -: 8], 8'(l) - 8'd1);
        if (l != 0 && (c & 4'hB) inside {4'h8, 4'h0, 4'h2})
          chk(cap_tx[FW-33 -: 8] == 8'hA0, $sformatf("R1 payload vec%0d", v), cap_tx[FW-33 -: 8], 8'hA0);
      end
      if (est == 3'd0) begin
        chk(got_reply == r0[7:4], $sformatf("R9 R10 reply vec%0d", v), got_reply, r0[7:4]);
        if ((c & 4'hB) inside {4'h9, 4'h1})
          chk(got_rdata[RW-1 -: 8] == r1, $sformatf("R9 payload vec%0d", v), got_rdata[RW-1 -: 8], r1);
      end
    end

    // R6 R8: five timeouts
    drv_rxlen = 5'd2; drv_rx0 = 8'h00; drv_rx1 = 8'h00;
    set_script(2'b10, 2'b10, 2'b10, 2'b10, 2'b10);
    transact(4'h9, 20'h01000, 5'd1);
    chk(got_st == 3'd3, "R8 all timeouts status", got_st, 3);
    chk(n_starts == 5, "R6 attempt limit", n_starts, 5);
    chk(n_clears == 5, "R7 clear per attempt", n_clears, 5);

    // R6 spacing: timeout then ok
    set_script(2'b10, 2'b00, 2'b00, 2'b00, 2'b00);
    transact(4'h9, 20'h01100, 5'd1);
    gap_to = start_cyc[1] - start_cyc[0];
    chk(got_st == 3'd0 && n_starts == 2, "R6 retry after timeout", n_starts, 2);
    // rx error then ok
    set_script(2'b01, 2'b00, 2'b00, 2'b00, 2'b00);
    transact(4'h9, 20'h01200, 5'd1);
    gap_re = start_cyc[1] - start_cyc[0];
    chk(got_st == 3'd0 && n_starts == 2, "R6 retry after rx error", n_starts, 2);
    chk(gap_re - gap_to == RXW, "R6 rx error pause", gap_re - gap_to, RXW);

    // R8 both flags on final attempt -> rx error
    set_script(2'b11, 2'b11, 2'b11, 2'b11, 2'b11);
    transact(4'h8, 20'h01300, 5'd2);
    chk(got_st == 3'd2, "R8 rx error priority", got_st, 2);
    set_script(2'b01, 2'b01, 2'b01, 2'b01, 2'b10);
    transact(4'h8, 20'h01400, 5'd2);
    chk(got_st == 3'd3, "R8 final timeout", got_st, 3);
    chk(got_cnt == 5'd0, "R8 count on failure", got_cnt, 0);

    // R5 busy held through all polls
    set_script(2'b00, 2'b00, 2'b00, 2'b00, 2'b00);
    ctl_busy = 1'b1;
    transact(4'h9, 20'h01500, 5'd1);
    chk(got_st == 3'd1 && n_starts == 0, "R5 busy status", got_st, 1);
    chk(rsp_cyc - acc_cyc >= 2 * GAP && rsp_cyc - acc_cyc <= 2 * GAP + 10,
        "R5 busy poll span", rsp_cyc - acc_cyc, 2 * GAP);
    // R5 busy released between polls
    fork
      begin repeat (GAP + GAP / 2) @(negedge clk); ctl_busy = 1'b0; end
      transact(4'h9, 20'h01600, 5'd1);
    join
    chk(got_st == 3'd0 && n_starts == 1, "R5 start after release", n_starts, 1);

    // R12 request while in flight is ignored
    inject = 1;
    transact(4'h9, 20'h01700, 5'd1);
    inject = 0;
    chk(got_st == 3'd0, "R12 in-flight request ignored status", got_st, 0);
    begin
      int extra = 0;
      for (int i = 0; i < 10; i++) begin
        @(negedge clk);
        if (rsp_valid) extra++;
      end
      chk(extra == 0, "R12 no extra response", extra, 0);
    end
    chk(req_ready == 1'b1, "R12 ready after response", req_ready, 1);

    finish_run();
  end
endmodule